// File: doc/BRIEF.md
# Key Matrix Scanner with Packed Byte Readout

This block scans a matrix of 12 source lines by 4 return inputs, 48 keys in all. The source lines are the same pins that carry the display segment outputs. The block drives them for key scanning only while the display timing asserts a scan slot, and it leaves them low for the rest of the time. During each scan slot, one source line at a time is driven high for a fixed number of clock cycles. The four return inputs are sampled on the last of those cycles.

Samples are collected in a shadow store. They move into the 48-bit key memory only when a complete pass over all 12 lines finishes, so a reader never sees part of one scan mixed with part of another. A serial front end reads the memory as six bytes. Each byte carries two adjacent source lines. A read session runs from the request for byte 0 to the request for byte 5, and no scan result is committed during a session.

Top module: `key_matrix_scanner`

## Requirements
- R1: After reset, all source outputs are low, the read byte is 0x00, the valid strobe is low, and every byte read before a scan completes returns 0x00.
- R2: While the scan slot is high, exactly one source output is high. Lines run in ascending order from line 1 to line 12 and then wrap to line 1. Each line stays high for HOLD clock cycles in which the slot is high.
- R3: While the scan slot is low, every source output is low. The scan position and the hold count are frozen during that time, and the scan resumes at the same place when the slot returns.
- R4: Byte k (k = 0..5) holds source line 2k+1 in bits 3:0 and source line 2k+2 in bits 7:4. Within each nibble, bit r holds return input r+1, and 1 means the key is pressed.
- R5: A read request with an index presents the selected byte on the cycle after the request and pulses the valid output high for that one cycle. The valid output is low after any cycle without a request.
- R6: A read request with an index of 6 or 7 returns 0x00 and has no effect on a read session.
- R7: The key memory changes only at the clock edge that samples line 12 and completes a full scan. A pass that is still in progress is never visible in the readback.
- R8: A request for byte 0 opens a read session, and a request for byte 5 closes it. A full scan that completes while a session is open, including the edge of the opening request, is discarded, and the memory keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_slot_i | input | 1 | Key scan slot from the display timing |
| key_i | input | N_RET (4) | Return inputs, active high |
| rd_req_i | input | 1 | Byte read request, one cycle per byte |
| rd_idx_i | input | IDX_W (3) | Index of the requested byte |
| src_drive_o | output | N_SRC (12) | Source line drive, bit 0 is line 1 |
| rd_byte_o | output | 2*N_RET (8) | Byte that was read |
| rd_valid_o | output | 1 | High on the cycle that rd_byte_o is valid |

## Verification
The hardest cases to reach are two. In the first, the key pattern changes one sample before a scan finishes. In the second, a scan completes while a read session is open. Neither case can be observed directly at the ports. The bench counts every clock edge on which the scan slot is high, so it always knows the scan phase. It aligns each pattern change to a scan boundary and then stops exactly one edge short of completion, or it keeps the slot high through two full passes between the byte-0 and byte-5 requests. The readback at those points then shows whether the memory kept its old contents.

// File: rtl/kms_pkg.sv
package kms_pkg;
  // Read session state.
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_OPEN = 1'b1
  } rd_state_e;

  localparam int unsigned KMS_DEF_SRC  = 12;
  localparam int unsigned KMS_DEF_RET  = 4;
  localparam int unsigned KMS_DEF_HOLD = 4;
endpackage

// File: rtl/kms_sequencer.sv
// Walks the source lines in ascending order. Both counters advance only
// while the scan slot is high.
module kms_sequencer #(
  parameter int unsigned N_SRC  = 12,
  parameter int unsigned HOLD   = 4,
  parameter int unsigned LINE_W = 4,
  parameter int unsigned HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_i,
  output logic [LINE_W-1:0] line_o,
  output logic              sample_o,
  output logic              scan_end_o
);
  logic [LINE_W-1:0] line_q;
  logic [HOLD_W-1:0] hold_q;
  logic              last_hold;
  logic              last_line;

  assign last_hold  = (hold_q == HOLD_W'(HOLD - 1));
  assign last_line  = (line_q == LINE_W'(N_SRC - 1));
  assign sample_o   = slot_i && last_hold;
  assign scan_end_o = sample_o && last_line;
  assign line_o     = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      hold_q <= '0;
    end else if (slot_i) begin
      if (last_hold) begin
        hold_q <= '0;
        line_q <= last_line ? '0 : line_q + 1'b1;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kms_capture.sv
// Shadow store for the scan in progress. The key memory takes a complete
// pass only at the end of a scan, and only when no read session holds it.
module kms_capture #(
  parameter int unsigned N_SRC  = 12,
  parameter int unsigned N_RET  = 4,
  parameter int unsigned LINE_W = 4,
  parameter int unsigned MEM_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              scan_end_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [N_RET-1:0]  key_i,
  input  logic              freeze_i,
  output logic [MEM_W-1:0]  mem_o,
  output logic              commit_o
);
  logic [MEM_W-1:0] shadow_q;
  logic [MEM_W-1:0] shadow_nx;
  logic [MEM_W-1:0] mem_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    logic hit;
    assign hit = sample_i && (line_i == LINE_W'(g));
    assign shadow_nx[g*N_RET +: N_RET] = hit ? key_i : shadow_q[g*N_RET +: N_RET];
  end

  assign commit_o = scan_end_i && !freeze_i;
  assign mem_o    = mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      mem_q    <= '0;
    end else begin
      shadow_q <= shadow_nx;
      if (commit_o) mem_q <= shadow_nx;
    end
  end
endmodule

// File: rtl/kms_readout.sv
// Byte readout with read-session tracking.
module kms_readout
  import kms_pkg::*;
#(
  parameter int unsigned N_RET   = 4,
  parameter int unsigned N_BYTES = 6,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned MEM_W   = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  input  logic [MEM_W-1:0]   mem_i,
  output logic [2*N_RET-1:0] rd_byte_o,
  output logic               rd_valid_o,
  output logic               busy_o,
  output logic               freeze_o
);
  localparam int unsigned BYTE_W = 2 * N_RET;

  // Byte b covers lines 2b and 2b+1 (0-based); the lower line sits in the low nibble.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [MEM_W-1:0] m,
                                                  input logic [IDX_W-1:0] i);
    pick_byte = '0;
    for (int b = 0; b < int'(N_BYTES); b++)
      if (int'(i) == b) pick_byte = m[b*BYTE_W +: BYTE_W];
  endfunction

  rd_state_e st_q;
  logic      open_req;
  logic      close_req;

  assign open_req  = rd_req_i && (int'(rd_idx_i) == 0);
  assign close_req = rd_req_i && (int'(rd_idx_i) == int'(N_BYTES) - 1);
  assign busy_o    = (st_q == RD_OPEN);
  assign freeze_o  = busy_o || open_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= RD_IDLE;
      rd_byte_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      if (close_req)     st_q <= RD_IDLE;
      else if (open_req) st_q <= RD_OPEN;
      rd_valid_o <= rd_req_i;
      if (rd_req_i) rd_byte_o <= pick_byte(mem_i, rd_idx_i);
    end
  end
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner
  import kms_pkg::*;
#(
  parameter int unsigned N_SRC = KMS_DEF_SRC,
  parameter int unsigned N_RET = KMS_DEF_RET,
  parameter int unsigned HOLD  = KMS_DEF_HOLD
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scan_slot_i,
  input  logic [N_RET-1:0]              key_i,
  input  logic                          rd_req_i,
  input  logic [$clog2(N_SRC/2)-1:0]    rd_idx_i,
  output logic [N_SRC-1:0]              src_drive_o,
  output logic [2*N_RET-1:0]            rd_byte_o,
  output logic                          rd_valid_o
);
  localparam int unsigned LINE_W  = $clog2(N_SRC);
  localparam int unsigned HOLD_W  = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int unsigned N_BYTES = N_SRC / 2;
  localparam int unsigned IDX_W   = $clog2(N_BYTES);
  localparam int unsigned MEM_W   = N_SRC * N_RET;

  function automatic logic [N_SRC-1:0] line_onehot(input logic [LINE_W-1:0] l);
    for (int k = 0; k < int'(N_SRC); k++) line_onehot[k] = (int'(l) == k);
  endfunction

  // Internal events, named for the checker.
  logic [LINE_W-1:0] line_w;
  logic              sample_w;
  logic              scan_end_w;
  logic              commit_w;
  logic              freeze_w;
  logic              read_busy_w;
  logic [MEM_W-1:0]  key_mem_w;

  kms_sequencer #(
    .N_SRC(N_SRC), .HOLD(HOLD), .LINE_W(LINE_W), .HOLD_W(HOLD_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_i(scan_slot_i),
    .line_o(line_w), .sample_o(sample_w), .scan_end_o(scan_end_w)
  );

  assign src_drive_o = scan_slot_i ? line_onehot(line_w) : '0;

  kms_capture #(
    .N_SRC(N_SRC), .N_RET(N_RET), .LINE_W(LINE_W), .MEM_W(MEM_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_w), .scan_end_i(scan_end_w),
    .line_i(line_w), .key_i(key_i), .freeze_i(freeze_w),
    .mem_o(key_mem_w), .commit_o(commit_w)
  );

  kms_readout #(
    .N_RET(N_RET), .N_BYTES(N_BYTES), .IDX_W(IDX_W), .MEM_W(MEM_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i), .rd_idx_i(rd_idx_i),
    .mem_i(key_mem_w), .rd_byte_o(rd_byte_o), .rd_valid_o(rd_valid_o),
    .busy_o(read_busy_w), .freeze_o(freeze_w)
  );
endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int unsigned N_SRC   = 12,
  parameter int unsigned N_RET   = 4,
  parameter int unsigned N_BYTES = 6,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned MEM_W   = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_slot_i,
  input logic               rd_req_i,
  input logic [IDX_W-1:0]   rd_idx_i,
  input logic [N_SRC-1:0]   src_drive_o,
  input logic [2*N_RET-1:0] rd_byte_o,
  input logic               rd_valid_o,
  input logic               sample_w,
  input logic               scan_end_w,
  input logic               commit_w,
  input logic               read_busy_w,
  input logic [MEM_W-1:0]   key_mem_w
);
  assert_src_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_drive_o));

  assert_src_active_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_slot_i |-> $countones(src_drive_o) == 1);

  assert_src_idle_outside_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_slot_i |-> src_drive_o == '0);

  assert_sample_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_w |-> scan_slot_i);

  assert_valid_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_valid_o);

  assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_valid_o);

  assert_range_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && int'(rd_idx_i) >= int'(N_BYTES)) |=> rd_byte_o == '0);

  assert_mem_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_w |=> $stable(key_mem_w));

  assert_commit_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |-> scan_end_w);

  assert_no_commit_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    read_busy_w |-> !commit_w);
endmodule

bind key_matrix_scanner kms_checker #(
  .N_SRC(N_SRC), .N_RET(N_RET), .N_BYTES(N_BYTES), .IDX_W(IDX_W), .MEM_W(MEM_W)
) u_kms_checker (
  .clk(clk), .rst_n(rst_n), .scan_slot_i(scan_slot_i),
  .rd_req_i(rd_req_i), .rd_idx_i(rd_idx_i), .src_drive_o(src_drive_o),
  .rd_byte_o(rd_byte_o), .rd_valid_o(rd_valid_o), .sample_w(sample_w),
  .scan_end_w(scan_end_w), .commit_w(commit_w), .read_busy_w(read_busy_w),
  .key_mem_w(key_mem_w)
);

// File: tb/test_key_matrix_scanner.sv
module test_key_matrix_scanner;
  localparam int NS = 12, NR = 4, HOLD = 2, SCAN = NS * HOLD, NB = NS / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot = 1'b0;
  logic [NR-1:0] key;
  logic          rd_req = 1'b0;
  logic [2:0]    rd_idx = '0;
  logic [NS-1:0] src;
  logic [7:0]    rd_byte;
  logic          rd_valid;
  logic [NS*NR-1:0] press = '0;
  int slot_edges = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  key_matrix_scanner #(.N_SRC(NS), .N_RET(NR), .HOLD(HOLD)) i_key_matrix_scanner (
    .clk(clk), .rst_n(rst_n), .scan_slot_i(slot), .key_i(key),
    .rd_req_i(rd_req), .rd_idx_i(rd_idx), .src_drive_o(src),
    .rd_byte_o(rd_byte), .rd_valid_o(rd_valid)
  );

  // Key matrix model: a pressed key connects its source line to its return input.
  always_comb begin
    key = '0;
    for (int l = 0; l < NS; l++)
      if (src[l]) key = key | press[l*NR +: NR];
  end

  always @(posedge clk) if (rst_n && slot) slot_edges <= slot_edges + 1;

  // Expected byte assembled bit by bit from the packing rule (R4, R6).
  function automatic logic [7:0] exp_byte(input logic [NS*NR-1:0] p, input int k);
    exp_byte = '0;
    for (int l = 0; l < NS; l++)
      for (int r = 0; r < NR; r++)
        if (l / 2 == k) exp_byte[(l % 2) * NR + r] = p[l*NR + r];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input int n, input bit s);
    slot = s;
    repeat (n) @(negedge clk);
    slot = 1'b0;
  endtask

  task automatic align();
    while (slot_edges % SCAN != 0) run(1, 1'b1);
  endtask

  task automatic read_byte(input int k, output logic [7:0] b);
    rd_req = 1'b1;
    rd_idx = 3'(k);
    @(negedge clk);
    rd_req = 1'b0;
    b = rd_byte;
    chk("R5 valid", 32'(rd_valid), 32'd1);
  endtask

  task automatic read_all(input logic [NS*NR-1:0] p, input string req);
    logic [7:0] b;
    for (int k = 0; k < NB; k++) begin
      read_byte(k, b);
      chk(req, 32'(b), 32'(exp_byte(p, k)));
    end
  endtask

  initial begin
    #(8 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [NS*NR-1:0] pa, pb, pc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 src", 32'(src), 32'd0);
    chk("R1 byte", 32'(rd_byte), 32'd0);
    chk("R1 valid", 32'(rd_valid), 32'd0);
    read_all('0, "R1 read");

    // R2/R3: line order, hold length and wrap, with gaps in the slot
    for (int i = 0; i < 4 * SCAN; i++) begin
      slot = (i % 7 != 3) && (i % 11 != 5);
      #0;
      #1;
      if (slot) chk("R2 drive", 32'(src), 32'(1 << ((slot_edges / HOLD) % NS)));
      else      chk("R3 idle", 32'(src), 32'd0);
      @(negedge clk);
    end
    slot = 1'b0;
    @(negedge clk);
    chk("R5 valid low", 32'(rd_valid), 32'd0);

    // R4: single-key sweep across all 48 keys, then dense patterns
    for (int bit_i = 0; bit_i < NS * NR + 2; bit_i++) begin
      if (bit_i < NS * NR) press = (NS*NR)'(1) << bit_i;
      else if (bit_i == NS * NR) press = '1;
      else press = {(NS*NR/2){2'b10}};
      run(2 * SCAN, 1'b1);
      read_all(press, "R4 pack");
    end

    // R6: out-of-range index reads zero with nonzero memory
    read_byte(6, b); chk("R6 idx6", 32'(b), 32'd0);
    read_byte(7, b); chk("R6 idx7", 32'(b), 32'd0);

    // R7: partial scan invisible; commit on the completing edge
    pa = {12{4'b0101}};
    pb = {12{4'b1010}};
    press = pa;
    run(2 * SCAN, 1'b1);
    align();
    read_all(pa, "R7 base");
    press = pb;
    run(SCAN - 1, 1'b1);
    read_all(pa, "R7 partial");
    run(1, 1'b1);
    read_all(pb, "R7 complete");

    // R8: scans during a read session are discarded
    pc = 48'h0123_4567_89AB;
    press = pc;
    read_byte(0, b);
    chk("R8 first", 32'(b), 32'(exp_byte(pb, 0)));
    run(2 * SCAN, 1'b1);
    for (int k = 1; k < NB; k++) begin
      read_byte(k, b);
      chk("R8 frozen", 32'(b), 32'(exp_byte(pb, k)));
    end
    read_all(pb, "R8 dropped");
    run(2 * SCAN, 1'b1);
    read_all(pc, "R8 resumed");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule